// File: doc/BRIEF.md
# Ring Port Bubble Admission Controller

This block sits in front of one unidirectional ring output of a torus router and decides, cycle by cycle, which packet may claim space in the downstream ring buffer. It tracks a free-flit credit level for each virtual channel of the downstream buffer. Two requesters can present a packet header in the same cycle. One is a packet already travelling along this ring. The other is a packet entering the ring, either injected by the local node or turning in from another dimension.

A packet already in the ring is admitted when its whole length fits in the free credits. An entering packet is admitted only if, after it is accepted, one full packet-sized hole (the bubble) still remains in the buffer on that virtual channel. This keeps the ring from filling completely, so it cannot deadlock. Only one packet is granted per cycle, and the in-transit requester wins any conflict. The grant is registered and the credit level is updated at the same edge, so a request in the very next cycle is judged against the reduced level. Credit return pulses from downstream restore one flit each.

Requests are evaluated in the cycle they are presented. The result appears on the grant outputs one clock later, together with the updated credit levels.

Top module: `ring_admit`

## Requirements
- R1: While `rst` is high and at the first edge after it, both grant outputs are 0 and every VC credit level equals BUF_FLITS (8).
- R2: An in-transit request with length L on VC v is granted, one cycle later on `gnt_transit`, exactly when the level of v is at least L.
- R3: An entering request with length L on VC v is granted on `gnt_enter` exactly when the level of v is at least L + BUBBLE (BUBBLE = 2 flits), and no in-transit request is present.
- R4: Injected packets (`en_turn`=0) and turning packets (`en_turn`=1) follow the same bubble rule, and `gnt_turn` echoes the class of the granted entering packet.
- R5: When an in-transit request is present, no entering packet is granted in that cycle, even if the in-transit packet itself is refused. At most one grant is high per cycle.
- R6: A grant lowers the level of the granted VC by the packet length at the same edge. A request in the following cycle sees the lowered level.
- R7: Each `cred_ret[v]` pulse raises the level of v by one flit. A pulse that would take the level above BUF_FLITS is ignored.
- R8: A grant and a credit return on the same VC in the same cycle give a net level change of 1 − L.
- R9: A request with length 0 or length above MAX_PKT (2) is never granted and leaves the levels unchanged.
- R10: `gnt_vc` and `gnt_len` carry the VC and length of the packet granted. The levels of other VCs are unaffected by that grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tr_req | input | 1 | In-transit packet header requests the port |
| tr_vc | input | VC_W | VC of the in-transit packet |
| tr_len | input | LEN_W | Length in flits of the in-transit packet |
| en_req | input | 1 | Entering (injected or turning) packet requests the port |
| en_turn | input | 1 | 1 = turning from another dimension, 0 = local injection |
| en_vc | input | VC_W | VC of the entering packet |
| en_len | input | LEN_W | Length in flits of the entering packet |
| cred_ret | input | NUM_VC | One-flit credit return pulse per VC |
| gnt_transit | output | 1 | Registered grant to the in-transit request |
| gnt_enter | output | 1 | Registered grant to the entering request |
| gnt_turn | output | 1 | Class of the granted entering packet |
| gnt_vc | output | VC_W | VC whose credits were taken |
| gnt_len | output | LEN_W | Flits taken by the grant |
| credit_lvl | output | NUM_VC*CNT_W | Registered free-flit level per VC, VC 0 in the low bits |

## Verification
Two pairs of functions can coincide in one cycle: the in-transit and entering requests competing for the port, and a credit taken by a grant alongside a credit returned on the same VC. The bench provokes both with directed cases. These include a refused in-transit request shadowing an entering request that would have fit, and a grant with a return at the full level. Long random runs then drive both requesters and the return pulses independently. A bench model computes each cycle's expected grant and levels from the rules above. The bench compares the model with the outputs one cycle after each request and attributes a mismatch to the conflict or accounting rule involved.

// File: rtl/ring_admit_pkg.sv
package ring_admit_pkg;

  // which requester owns the ring port in a cycle
  typedef enum logic [1:0] {
    GK_NONE    = 2'd0,
    GK_TRANSIT = 2'd1,
    GK_ENTER   = 2'd2
  } grant_kind_t;

endpackage

// File: rtl/ra_admit_check.sv
// Combinational fit test for one requester: length sanity plus room,
// with a bubble reserve added when the packet is entering the ring.
module ra_admit_check #(
  parameter int CNT_W   = 4,
  parameter int LEN_W   = 2,
  parameter int MAX_PKT = 2,
  parameter int BUBBLE  = 2
) (
  input  logic [CNT_W-1:0] level,
  input  logic [LEN_W-1:0] len,
  input  logic             entering,
  output logic             ok
);
  localparam int SUM_W = ((CNT_W > LEN_W) ? CNT_W : LEN_W) + 3;

  logic [SUM_W-1:0] need;
  logic [SUM_W-1:0] have;
  logic             len_ok;

  always_comb begin
    have   = SUM_W'(level);
    need   = SUM_W'(len) + (entering ? SUM_W'(BUBBLE) : '0);
    len_ok = (len != '0) && (SUM_W'(len) <= SUM_W'(MAX_PKT));
    ok     = len_ok && (have >= need);
  end
endmodule

// File: rtl/ra_port_select.sv
// Fixed priority: in-transit traffic owns the port whenever it asks.
module ra_port_select
  import ring_admit_pkg::*;
(
  input  logic        tr_req,
  input  logic        tr_ok,
  input  logic        en_req,
  input  logic        en_ok,
  output grant_kind_t kind
);
  always_comb begin
    kind = GK_NONE;
    if (tr_req) begin
      if (tr_ok) kind = GK_TRANSIT;
    end else if (en_req && en_ok) begin
      kind = GK_ENTER;
    end
  end
endmodule

// File: rtl/ra_credit_ctr.sv
// Free-flit level of one downstream VC buffer.
module ra_credit_ctr #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic [CNT_W-1:0] take_amt,
  input  logic             ret,
  output logic [CNT_W-1:0] level
);
  logic [CNT_W-1:0] after_take;
  logic [CNT_W-1:0] nxt;

  always_comb begin
    after_take = take ? (level - take_amt) : level;
    nxt        = after_take;
    if (ret && (after_take < CNT_W'(DEPTH))) nxt = after_take + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) level <= CNT_W'(DEPTH);
    else     level <= nxt;
  end

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    level <= CNT_W'(DEPTH));

  assert_take_fits_R6: assert property (@(posedge clk) disable iff (rst)
    take |-> (take_amt <= level));

  assert_return_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!take && ret && level < CNT_W'(DEPTH)) |=> level == $past(level) + 1'b1);
endmodule

// File: rtl/ring_admit.sv
module ring_admit
  import ring_admit_pkg::*;
#(
  parameter int NUM_VC    = 2,
  parameter int BUF_FLITS = 8,
  parameter int MAX_PKT   = 2,
  parameter int BUBBLE    = MAX_PKT,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int LEN_W = $clog2(MAX_PKT + 1) + 1,
  localparam int CNT_W = $clog2(BUF_FLITS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    tr_req,
  input  logic [VC_W-1:0]         tr_vc,
  input  logic [LEN_W-1:0]        tr_len,
  input  logic                    en_req,
  input  logic                    en_turn,
  input  logic [VC_W-1:0]         en_vc,
  input  logic [LEN_W-1:0]        en_len,
  input  logic [NUM_VC-1:0]       cred_ret,
  output logic                    gnt_transit,
  output logic                    gnt_enter,
  output logic                    gnt_turn,
  output logic [VC_W-1:0]         gnt_vc,
  output logic [LEN_W-1:0]        gnt_len,
  output logic [NUM_VC*CNT_W-1:0] credit_lvl
);

  logic [CNT_W-1:0] lvl [NUM_VC];
  logic [CNT_W-1:0] tr_lvl, en_lvl;
  logic             tr_vc_ok, en_vc_ok;
  logic             tr_fit, en_fit;
  grant_kind_t      kind;
  logic [VC_W-1:0]  win_vc;
  logic [LEN_W-1:0] win_len;

  // level seen by each requester
  always_comb begin
    tr_lvl   = '0;
    en_lvl   = '0;
    tr_vc_ok = 1'b0;
    en_vc_ok = 1'b0;
    for (int i = 0; i < NUM_VC; i++) begin
      if (tr_vc == VC_W'(i)) begin tr_lvl = lvl[i]; tr_vc_ok = 1'b1; end
      if (en_vc == VC_W'(i)) begin en_lvl = lvl[i]; en_vc_ok = 1'b1; end
    end
  end

  logic tr_ok_raw, en_ok_raw;

  ra_admit_check #(.CNT_W(CNT_W), .LEN_W(LEN_W), .MAX_PKT(MAX_PKT), .BUBBLE(BUBBLE))
    u_fit_transit (.level(tr_lvl), .len(tr_len), .entering(1'b0), .ok(tr_ok_raw));

  ra_admit_check #(.CNT_W(CNT_W), .LEN_W(LEN_W), .MAX_PKT(MAX_PKT), .BUBBLE(BUBBLE))
    u_fit_enter (.level(en_lvl), .len(en_len), .entering(1'b1), .ok(en_ok_raw));

  assign tr_fit = tr_ok_raw && tr_vc_ok;
  assign en_fit = en_ok_raw && en_vc_ok;

  ra_port_select u_select (
    .tr_req (tr_req),
    .tr_ok  (tr_fit),
    .en_req (en_req),
    .en_ok  (en_fit),
    .kind   (kind)
  );

  always_comb begin
    win_vc  = (kind == GK_TRANSIT) ? tr_vc  : en_vc;
    win_len = (kind == GK_TRANSIT) ? tr_len : en_len;
  end

  // one credit counter per VC
  for (genvar g = 0; g < NUM_VC; g++) begin : g_vc
    logic take_here;
    assign take_here = (kind != GK_NONE) && (win_vc == VC_W'(g));

    ra_credit_ctr #(.DEPTH(BUF_FLITS), .CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst      (rst),
      .take     (take_here),
      .take_amt (CNT_W'(win_len)),
      .ret      (cred_ret[g]),
      .level    (lvl[g])
    );

    assign credit_lvl[g*CNT_W +: CNT_W] = lvl[g];
  end

  // registered grant outputs, aligned with the counter update
  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_transit <= 1'b0;
      gnt_enter   <= 1'b0;
      gnt_turn    <= 1'b0;
      gnt_vc      <= '0;
      gnt_len     <= '0;
    end else begin
      gnt_transit <= (kind == GK_TRANSIT);
      gnt_enter   <= (kind == GK_ENTER);
      gnt_turn    <= (kind == GK_ENTER) && en_turn;
      gnt_vc      <= win_vc;
      gnt_len     <= (kind == GK_NONE) ? '0 : win_len;
    end
  end

  function automatic int lvl_of(input logic [NUM_VC*CNT_W-1:0] v, input logic [VC_W-1:0] i);
    return int'(v[int'(i)*CNT_W +: CNT_W]);
  endfunction

  assert_one_grant_R5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({gnt_transit, gnt_enter}));

  assert_transit_first_R5: assert property (@(posedge clk) disable iff (rst)
    gnt_enter |-> !$past(tr_req));

  assert_bubble_kept_R3: assert property (@(posedge clk) disable iff (rst)
    gnt_enter |-> lvl_of($past(credit_lvl), gnt_vc) >= int'(gnt_len) + BUBBLE);

  assert_transit_fits_R2: assert property (@(posedge clk) disable iff (rst)
    gnt_transit |-> lvl_of($past(credit_lvl), gnt_vc) >= int'(gnt_len));

  assert_len_sane_R9: assert property (@(posedge clk) disable iff (rst)
    (gnt_transit || gnt_enter) |-> (gnt_len != '0 && int'(gnt_len) <= MAX_PKT));

  assert_turn_only_enter_R4: assert property (@(posedge clk) disable iff (rst)
    gnt_turn |-> gnt_enter);
endmodule

// File: tb/tb_ring_admit.sv
module tb_ring_admit;
  localparam int NVC = 2, DEPTH = 8, MAXP = 2, BUB = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tr_req = 0, en_req = 0, en_turn = 0;
  logic [0:0] tr_vc = 0, en_vc = 0;
  logic [2:0] tr_len = 0, en_len = 0;
  logic [1:0] cred_ret = 0;
  logic       gnt_transit, gnt_enter, gnt_turn;
  logic [0:0] gnt_vc;
  logic [2:0] gnt_len;
  logic [7:0] credit_lvl;

  int total = 0, bad = 0;
  int lv [NVC];
  bit done = 0;

  always #4 clk = ~clk;

  ring_admit dut (
    .clk(clk), .rst(rst), .tr_req(tr_req), .tr_vc(tr_vc), .tr_len(tr_len),
    .en_req(en_req), .en_turn(en_turn), .en_vc(en_vc), .en_len(en_len),
    .cred_ret(cred_ret), .gnt_transit(gnt_transit), .gnt_enter(gnt_enter),
    .gnt_turn(gnt_turn), .gnt_vc(gnt_vc), .gnt_len(gnt_len), .credit_lvl(credit_lvl)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit len_ok(input int l);
    return (l >= 1) && (l <= MAXP);
  endfunction

  function automatic bit fits(input int level, input int l, input bit entering);
    return len_ok(l) && (level >= l + (entering ? BUB : 0));
  endfunction

  task automatic step(input bit trq, input int tvc, input int tlen,
                      input bit erq, input bit eturn, input int evc, input int elen,
                      input bit r0, input bit r1);
    bit eg_t, eg_e;
    int wvc, wlen;
    int nlv [NVC];
    bit [1:0] rr;
    string gtag, ltag;
    tr_req = trq; tr_vc = 1'(tvc); tr_len = 3'(tlen);
    en_req = erq; en_turn = eturn; en_vc = 1'(evc); en_len = 3'(elen);
    cred_ret = {r1, r0};
    rr = {r1, r0};
    eg_t = trq && fits(lv[tvc], tlen, 1'b0);
    eg_e = !trq && erq && fits(lv[evc], elen, 1'b1);
    wvc  = eg_t ? tvc : evc;
    wlen = eg_t ? tlen : elen;
    for (int v = 0; v < NVC; v++) begin
      nlv[v] = lv[v] - (((eg_t || eg_e) && wvc == v) ? wlen : 0);
      if (rr[v] && nlv[v] < DEPTH) nlv[v]++;
    end
    if (trq && erq) gtag = "R5";
    else if (erq && eturn) gtag = "R4";
    else if (erq) gtag = "R3";
    else if (trq && !len_ok(tlen)) gtag = "R9";
    else gtag = "R2";
    if (erq && !trq && !len_ok(elen)) gtag = "R9";
    if ((eg_t || eg_e) && rr[wvc]) ltag = "R8";
    else if (rr != 0) ltag = "R7";
    else ltag = "R6";
    @(posedge clk);
    @(negedge clk);
    chk(gnt_transit == eg_t, {gtag, " transit grant"}, gnt_transit, eg_t);
    chk(gnt_enter == eg_e, {gtag, " enter grant"}, gnt_enter, eg_e);
    if (eg_t || eg_e) begin
      chk(gnt_vc == 1'(wvc) && gnt_len == 3'(wlen), "R10 grant vc/len",
          {gnt_vc, gnt_len}, wvc * 8 + wlen);
      chk(gnt_turn == (eg_e && eturn), "R4 turn echo", gnt_turn, eg_e && eturn);
    end
    chk(credit_lvl == {4'(nlv[1]), 4'(nlv[0])}, {ltag, " credit levels"},
        credit_lvl, nlv[1] * 16 + nlv[0]);
    for (int v = 0; v < NVC; v++) lv[v] = nlv[v];
    tr_req = 0; en_req = 0; cred_ret = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk(gnt_transit == 0 && gnt_enter == 0, "R1 grants in reset", {gnt_transit, gnt_enter}, 0);
    chk(credit_lvl == 8'h88, "R1 levels in reset", credit_lvl, 8'h88);
    rst = 0;
    lv[0] = DEPTH; lv[1] = DEPTH;
    // R3/R6 entering packets back to back on VC0: 8->6->4->2, then refused
    step(0,0,0, 1,0,0,2, 0,0);
    step(0,0,0, 1,0,0,2, 0,0);
    step(0,0,0, 1,1,0,2, 0,0);
    step(0,0,0, 1,0,0,1, 0,0);  // 2 < 1+2: refused
    step(1,0,2, 0,0,0,0, 0,0);  // R2 transit takes the last two flits
    step(1,0,1, 0,0,0,0, 0,0);  // R2 nothing left
    // R7 returns refill VC0
    for (int k = 0; k < 3; k++) step(0,0,0, 0,0,0,0, 1,0);
    // R4 turning packet on VC1 at the bubble boundary
    step(0,0,0, 1,1,1,2, 0,0);  // 8->6
    step(0,0,0, 1,1,1,2, 0,0);  // 6->4
    step(0,0,0, 1,1,1,2, 0,0);  // 4->2
    step(0,0,0, 1,1,1,1, 0,0);  // refused
    // R5 refused transit still blocks a fitting entering packet
    step(1,1,2, 1,0,0,1, 0,0);  // VC1 level 2 fits transit
    step(1,1,1, 1,0,0,1, 0,0);  // VC1 empty: transit refused, enter blocked
    // R9 bad lengths
    step(1,0,0, 0,0,0,0, 0,0);
    step(0,0,0, 1,0,0,3, 0,0);
    // R8 grant and return together on VC0
    step(1,0,2, 0,0,0,0, 1,0);
    // R7 returns at full level ignored
    for (int k = 0; k < 12; k++) step(0,0,0, 0,0,0,0, 1,1);
    step(0,0,0, 0,0,0,0, 1,1);
    // random mix
    for (int n = 0; n < 3000; n++) begin
      step($urandom % 2, $urandom % 2, $urandom % 4,
           $urandom % 2, $urandom % 2, $urandom % 2, $urandom % 4,
           ($urandom % 5) < 2, ($urandom % 5) < 2);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule